// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the command pins of a flash array that uses a synchronous-DRAM-style interface. On each rising clock edge it decodes chip select, RAS, CAS and WE into one command. A self-timed array operation is armed by a load-command-register (LCR) cycle that carries an operation code on the low address bits. An activate cycle and a write cycle must follow, all on one bank. When the three steps arrive in order, the block pulses a launch strobe with the operation code and bank for the internal state machine. It then holds a busy flag until that machine reports completion.

The block keeps the open row of every bank. A read returns that row, or the busy flag when it addresses the status register. An activate that arrives as the second step of a sequence opens no row. While an operation runs, the busy bank's row is frozen, so reads there return the row that was open before the sequence started. A single-cycle mode command either writes the non-volatile mode register or clears a one-time hardware command-enable bit.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle, `busy`, `launch`, `seq_abort`, `rd_valid` and `nvmode_wr` are 0, `hw_cmd_en` is 1 and every bank's tracked row is 0.
- R2: Commands are decoded from {ras_n,cas_n,we_n} with cs_n=0: 001 LCR, 011 activate, 100 write, 101 read, 000 mode, and 111/110/010 are neutral (no-op, burst terminate, active terminate); cs_n=1 is inhibit, which is also neutral. LCR codes on addr[7:0] are 0x20 erase, 0x40 program, 0x60 block lock and 0x6F device lock. The sequence LCR, activate, write on one bank produces a one-cycle `launch` in the cycle after the write. `launch_op` is 1 for erase, 2 for program, 3 for block protect, 4 for device protect and 5 for unprotect. `launch_bank` is the LCR bank.
- R3: An activate that is the second step of a sequence opens no row.
- R4: A bank differing from the LCR bank on the activate or the write gives a one-cycle `seq_abort` and no launch. With the device-lock code the bank is not compared.
- R5: Neutral commands leave the sequence where it is. A further LCR with a valid code restarts the sequence at step two, using the new code and bank.
- R6: During a sequence, a read, a mode command, a write directly after the LCR, an activate after the activate, or an LCR with an unknown code aborts with `seq_abort`. An LCR with an unknown code while idle, or a write while idle, does nothing.
- R7: `busy` rises with `launch` and stays high until `ism_done`. A sequence that completes while busy aborts instead of launching.
- R8: An activate while idle stores addr as the bank's open row. A read (addr[11]=0) returns that row one cycle later with `rd_valid`. While busy, an activate to the busy bank is ignored.
- R9: A read with addr[11]=1 returns `rd_status`=1 and `rd_data` equal to the busy flag in bit 0 with zeros elsewhere.
- R10: A mode command in idle with ba[1]=0 gives a one-cycle `nvmode_wr` with `nvmode_data` = addr.
- R11: A mode command in idle with ba[1]=1 clears `hw_cmd_en`, which stays 0 until reset.
- R12: For the lock codes, the write data dq[7:0] picks the operation: 0x01 block protect (block code only), 0xF1 device protect (device code only), 0xD0 unprotect (either code). Any other value aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, high means inhibit |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write enable command bit |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row / code / mode data address |
| dq | input | 8 | Write data (lock data) |
| ism_done | input | 1 | Internal state machine finished |
| launch | output | 1 | One-cycle start strobe |
| launch_op | output | 3 | Operation to start |
| launch_bank | output | 2 | Bank of the started operation |
| busy | output | 1 | Operation in progress |
| busy_bank | output | 2 | Bank under operation |
| seq_abort | output | 1 | Sequence dropped without launch |
| rd_valid | output | 1 | Read result valid |
| rd_status | output | 1 | Read result is status |
| rd_data | output | 12 | Row or status read result |
| nvmode_wr | output | 1 | Mode register write strobe |
| nvmode_data | output | 12 | Mode register write value |
| hw_cmd_en | output | 1 | One-time hardware command-enable bit |

## Verification
A wrong sequencer state shows up at the ports one cycle after the offending write or activate: a launch that should not occur, a missing launch, or a `seq_abort` in the wrong cycle. A corrupted row table is visible on the very next read of that bank. The frozen-row rule shows up only on reads to the busy bank after an activate issued during the operation. The bench compares every launch, abort, read and mode strobe in order against a queue of expected events, so a missing or extra event misaligns all the comparisons that follow.

// File: rtl/fcsd_pkg.sv
// Shared types for the flash command sequence decoder.
// Assumes the SDRAM-style command encoding on {ras_n,cas_n,we_n}.
package fcsd_pkg;

    typedef enum logic [2:0] {
        CMD_NEUTRAL = 3'd0,
        CMD_ACTIVE  = 3'd1,
        CMD_READ    = 3'd2,
        CMD_WRITE   = 3'd3,
        CMD_LCR     = 3'd4,
        CMD_MODE    = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        SEQ_NONE     = 3'd0,
        SEQ_ERASE    = 3'd1,
        SEQ_PROGRAM  = 3'd2,
        SEQ_LOCK_BLK = 3'd3,
        SEQ_LOCK_DEV = 3'd4
    } seqk_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_ERASE    = 3'd1,
        OP_PROGRAM  = 3'd2,
        OP_PROT_BLK = 3'd3,
        OP_PROT_DEV = 3'd4,
        OP_UNPROT   = 3'd5
    } op_e;

    localparam logic [7:0] CODE_ERASE    = 8'h20;
    localparam logic [7:0] CODE_PROGRAM  = 8'h40;
    localparam logic [7:0] CODE_LOCK_BLK = 8'h60;
    localparam logic [7:0] CODE_LOCK_DEV = 8'h6F;

    localparam logic [7:0] LDAT_SET_BLK = 8'h01;
    localparam logic [7:0] LDAT_SET_DEV = 8'hF1;
    localparam logic [7:0] LDAT_CLEAR   = 8'hD0;

endpackage

// File: rtl/fcsd_cmd_decode.sv
// Combinational command and operation-code decoder.
// Assumes inputs are already synchronous to clk; produces no state.
module fcsd_cmd_decode
    import fcsd_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic [7:0] code_in,
    output cmd_e       cmd,
    output seqk_e      lcr_kind
);

    // Map the strobe pins onto one command.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NEUTRAL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACTIVE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b001:  cmd = CMD_LCR;
                3'b000:  cmd = CMD_MODE;
                default: cmd = CMD_NEUTRAL;
            endcase
        end
    end

    // Classify the operation code carried by an LCR cycle.
    always_comb begin
        unique case (code_in)
            CODE_ERASE:    lcr_kind = SEQ_ERASE;
            CODE_PROGRAM:  lcr_kind = SEQ_PROGRAM;
            CODE_LOCK_BLK: lcr_kind = SEQ_LOCK_BLK;
            CODE_LOCK_DEV: lcr_kind = SEQ_LOCK_DEV;
            default:       lcr_kind = SEQ_NONE;
        endcase
    end

endmodule

// File: rtl/fcsd_seq_fsm.sv
// Three-step sequencer: LCR, activate, write on one bank, then launch.
// Holds the busy flag until the internal state machine reports done.
// Assumes ism_done is only meaningful while busy.
module fcsd_seq_fsm
    import fcsd_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  seqk_e             lcr_kind,
    input  logic [BANK_W-1:0] ba,
    input  logic [7:0]        dq,
    input  logic              ism_done,
    output logic              launch,
    output op_e               launch_op,
    output logic [BANK_W-1:0] launch_bank,
    output logic              busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic              seq_abort,
    output logic              row_open_en,
    output logic              mode_en
);

    typedef enum logic [1:0] {ST_IDLE, ST_LCR, ST_ACT} st_e;

    st_e               st_q, st_d;
    seqk_e             kind_q, kind_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic              fire, abort, bank_ok;
    op_e               wr_op;

    // Bank check, waived for the device-lock code.
    assign bank_ok = (kind_q == SEQ_LOCK_DEV) || (ba == bank_q);

    // Only idle activates and idle mode commands take effect.
    assign row_open_en = (st_q == ST_IDLE) && (cmd == CMD_ACTIVE);
    assign mode_en     = (st_q == ST_IDLE) && (cmd == CMD_MODE);

    // Pick the operation from the armed code and the write data.
    always_comb begin
        wr_op = OP_NONE;
        unique case (kind_q)
            SEQ_ERASE:    wr_op = OP_ERASE;
            SEQ_PROGRAM:  wr_op = OP_PROGRAM;
            SEQ_LOCK_BLK: begin
                if (dq == LDAT_SET_BLK)    wr_op = OP_PROT_BLK;
                else if (dq == LDAT_CLEAR) wr_op = OP_UNPROT;
            end
            SEQ_LOCK_DEV: begin
                if (dq == LDAT_SET_DEV)    wr_op = OP_PROT_DEV;
                else if (dq == LDAT_CLEAR) wr_op = OP_UNPROT;
            end
            default:      wr_op = OP_NONE;
        endcase
    end

    // Next-state logic of the sequencer.
    always_comb begin
        st_d   = st_q;
        kind_d = kind_q;
        bank_d = bank_q;
        fire   = 1'b0;
        abort  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd == CMD_LCR && lcr_kind != SEQ_NONE) begin
                    st_d   = ST_LCR;
                    kind_d = lcr_kind;
                    bank_d = ba;
                end
            end
            ST_LCR, ST_ACT: begin
                if (cmd == CMD_NEUTRAL) begin
                    st_d = st_q;
                end else if (cmd == CMD_LCR && lcr_kind != SEQ_NONE) begin
                    st_d   = ST_LCR;
                    kind_d = lcr_kind;
                    bank_d = ba;
                end else if (st_q == ST_LCR && cmd == CMD_ACTIVE && bank_ok) begin
                    st_d = ST_ACT;
                end else if (st_q == ST_ACT && cmd == CMD_WRITE && bank_ok &&
                             wr_op != OP_NONE && !busy) begin
                    fire = 1'b1;
                    st_d = ST_IDLE;
                end else begin
                    abort = 1'b1;
                    st_d  = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (st_d == ST_IDLE) begin
            kind_d = SEQ_NONE;
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= SEQ_NONE;
            bank_q <= '0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            bank_q <= bank_d;
        end
    end

    // Registered launch, abort and busy outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch      <= 1'b0;
            launch_op   <= OP_NONE;
            launch_bank <= '0;
            seq_abort   <= 1'b0;
            busy        <= 1'b0;
            busy_bank   <= '0;
        end else begin
            launch    <= fire;
            launch_op <= fire ? wr_op : OP_NONE;
            seq_abort <= abort;
            if (fire) begin
                launch_bank <= bank_q;
                busy_bank   <= bank_q;
                busy        <= 1'b1;
            end else if (ism_done) begin
                busy <= 1'b0;
            end
        end
    end

    AST_LAUNCH_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> $past(st_q) == ST_ACT); // R2
    AST_LAUNCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> !launch); // R2
    AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(launch && seq_abort)); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ism_done |=> busy); // R7
    AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !launch); // R7

endmodule

// File: rtl/fcsd_row_track.sv
// Per-bank open-row table and read/status return path.
// Assumes the sequencer gates row opening to idle activates; the busy
// bank's row is frozen while an operation runs.
module fcsd_row_track #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] ba,
    input  logic [ROW_W-1:0]  row_in,
    input  logic              busy,
    input  logic [BANK_W-1:0] busy_bank,
    output logic              rd_valid,
    output logic              rd_status,
    output logic [ROW_W-1:0]  rd_data
);

    localparam int BANKS = 1 << BANK_W;

    logic [BANKS-1:0][ROW_W-1:0] rows;
    logic [ROW_W-1:0]            busy_row;
    logic                        status_sel;

    assign status_sel = row_in[ROW_W-1];
    assign busy_row   = rows[busy_bank];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [ROW_W-1:0] row_q;
        logic             hit, frozen;
        assign hit    = open_en && (ba == BANK_W'(b));
        assign frozen = busy && (busy_bank == BANK_W'(b));
        // Store a newly opened row unless this bank is under operation.
        always_ff @(posedge clk) begin
            if (!rst_n)            row_q <= '0;
            else if (hit && !frozen) row_q <= row_in;
        end
        assign rows[b] = row_q;
    end

    // Return a row or the status word one cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_status <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid  <= rd_en;
            rd_status <= rd_en && status_sel;
            if (rd_en) begin
                rd_data <= status_sel ? {{(ROW_W-1){1'b0}}, busy} : rows[ba];
            end
        end
    end

    AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> busy_row == $past(busy_row)); // R8
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R8

endmodule

// File: rtl/fcsd_mode_ctrl.sv
// Mode command handling: non-volatile mode write or one-time clearing of
// the hardware command-enable bit, chosen by the upper bank bit.
// Assumes mode_en is asserted only for mode commands accepted in idle.
module fcsd_mode_ctrl #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              sel_disable,
    input  logic [ADDR_W-1:0] addr,
    output logic              nvmode_wr,
    output logic [ADDR_W-1:0] nvmode_data,
    output logic              hw_cmd_en
);

    // Mode write strobe and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nvmode_wr   <= 1'b0;
            nvmode_data <= '0;
        end else begin
            nvmode_wr <= mode_en && !sel_disable;
            if (mode_en && !sel_disable) nvmode_data <= addr;
        end
    end

    // One-time enable bit: can only go from 1 to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hw_cmd_en <= 1'b1;
        else if (mode_en && sel_disable)     hw_cmd_en <= 1'b0;
    end

    AST_HWCMD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_cmd_en |=> !hw_cmd_en); // R11
    AST_NVWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !nvmode_wr); // R10

endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequence decoder: wires the pin decoder, the
// three-step sequencer, the row table and the mode handling together.
// Assumes all inputs are synchronous to clk.
module flash_cmd_seq
    import fcsd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq,
    input  logic              ism_done,
    output logic              launch,
    output logic [2:0]        launch_op,
    output logic [BANK_W-1:0] launch_bank,
    output logic              busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic              seq_abort,
    output logic              rd_valid,
    output logic              rd_status,
    output logic [ADDR_W-1:0] rd_data,
    output logic              nvmode_wr,
    output logic [ADDR_W-1:0] nvmode_data,
    output logic              hw_cmd_en
);

    cmd_e  cmd;
    seqk_e lcr_kind;
    op_e   op;
    logic  row_open_en, mode_en;

    fcsd_cmd_decode dec_i (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .code_in  (addr[7:0]),
        .cmd      (cmd),
        .lcr_kind (lcr_kind)
    );

    fcsd_seq_fsm #(.BANK_W(BANK_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .lcr_kind    (lcr_kind),
        .ba          (ba),
        .dq          (dq),
        .ism_done    (ism_done),
        .launch      (launch),
        .launch_op   (op),
        .launch_bank (launch_bank),
        .busy        (busy),
        .busy_bank   (busy_bank),
        .seq_abort   (seq_abort),
        .row_open_en (row_open_en),
        .mode_en     (mode_en)
    );

    assign launch_op = op;

    fcsd_row_track #(.BANK_W(BANK_W), .ROW_W(ADDR_W)) rows_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (row_open_en),
        .rd_en     (cmd == CMD_READ),
        .ba        (ba),
        .row_in    (addr),
        .busy      (busy),
        .busy_bank (busy_bank),
        .rd_valid  (rd_valid),
        .rd_status (rd_status),
        .rd_data   (rd_data)
    );

    fcsd_mode_ctrl #(.ADDR_W(ADDR_W)) mode_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_en     (mode_en),
        .sel_disable (ba[BANK_W-1]),
        .addr        (addr),
        .nvmode_wr   (nvmode_wr),
        .nvmode_data (nvmode_data),
        .hw_cmd_en   (hw_cmd_en)
    );

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
// Scoreboard bench: the driver queues expected events, the monitor pops
// and compares them whenever the design emits one.
module flash_cmd_seq_tb_top;

    localparam int  WD_CYCLES = 20000;
    localparam logic [2:0] C_NOP = 3'b111, C_BT = 3'b110, C_AT = 3'b010,
        C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_LCR = 3'b001,
        C_MODE = 3'b000;
    localparam logic [3:0] K_LAUNCH = 4'd1, K_ABORT = 4'd2, K_READ = 4'd3, K_NVM = 4'd4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [11:0] addr = '0;
    logic [7:0] dq = '0;
    logic ism_done = 1'b0;
    logic launch, busy, seq_abort, rd_valid, rd_status, nvmode_wr, hw_cmd_en;
    logic [2:0] launch_op;
    logic [1:0] launch_bank, busy_bank;
    logic [11:0] rd_data, nvmode_data;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [27:0] sbq[$];

    always #2 clk = ~clk;

    flash_cmd_seq dut_i (.*);

    task automatic expect_ev(input int req, input logic [3:0] kind, input logic [15:0] pay);
        sbq.push_back({req[7:0], kind, pay});
    endtask

    task automatic mon_take(input logic [3:0] kind, input logic [15:0] act);
        logic [27:0] e;
        checks++;
        if (sbq.size() == 0) begin
            failures++;
            $display("FAIL unexpected event kind=%0d actual=%h expected=none", kind, act);
        end else begin
            e = sbq.pop_front();
            if (e[19:16] != kind || e[15:0] != act) begin
                failures++;
                $display("FAIL R%0d kind actual=%0d expected=%0d data actual=%h expected=%h",
                         e[27:20], kind, e[19:16], act, e[15:0]);
            end
        end
    endtask

    // Monitor: compare every emitted event against the queue head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (launch)    mon_take(K_LAUNCH, {11'd0, launch_op, launch_bank});
            if (seq_abort) mon_take(K_ABORT, 16'd0);
            if (rd_valid)  mon_take(K_READ, {3'd0, rd_status, rd_data});
            if (nvmode_wr) mon_take(K_NVM, {4'd0, nvmode_data});
        end
    end

    task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] rcw, input logic [1:0] b,
                       input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = {1'b0, rcw};
        ba = b; addr = a; dq = d;
        @(posedge clk); #1;
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    endtask

    task automatic inhibit();
        @(negedge clk); cs_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic done_pulse();
        @(negedge clk); ism_done = 1'b1;
        @(posedge clk); #1; ism_done = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk(1, {15'd0, busy}, 16'd0);
        chk(1, {15'd0, launch}, 16'd0);
        chk(1, {15'd0, hw_cmd_en}, 16'd1);
        expect_ev(1, K_READ, 16'h0000);             // R1 row table cleared
        cmd(C_RD, 2'd0, 12'h000, 8'h00);

        // R8: idle activate opens a row
        cmd(C_ACT, 2'd1, 12'h155, 8'h00);
        expect_ev(8, K_READ, 16'h0155);
        cmd(C_RD, 2'd1, 12'h000, 8'h00);

        // R2/R3: erase on bank 1, activate in sequence opens no row
        cmd(C_LCR, 2'd1, 12'h020, 8'h00);
        cmd(C_ACT, 2'd1, 12'h0AA, 8'h00);
        expect_ev(2, K_LAUNCH, {11'd0, 3'd1, 2'd1});
        cmd(C_WR, 2'd1, 12'h000, 8'h00);
        chk(7, {15'd0, busy}, 16'd1);               // R7 busy with launch
        chk(7, {14'd0, busy_bank}, 16'd1);
        expect_ev(3, K_READ, 16'h0155);             // R3 old row kept
        cmd(C_RD, 2'd1, 12'h000, 8'h00);
        expect_ev(9, K_READ, 16'h1001);             // R9 status shows busy
        cmd(C_RD, 2'd0, 12'h800, 8'h00);
        cmd(C_ACT, 2'd1, 12'h333, 8'h00);           // R8 ignored while busy
        expect_ev(8, K_READ, 16'h0155);
        cmd(C_RD, 2'd1, 12'h000, 8'h00);
        cmd(C_ACT, 2'd2, 12'h222, 8'h00);
        expect_ev(8, K_READ, 16'h0222);
        cmd(C_RD, 2'd2, 12'h000, 8'h00);

        // R7: sequence completing while busy aborts
        cmd(C_LCR, 2'd2, 12'h040, 8'h00);
        cmd(C_ACT, 2'd2, 12'h000, 8'h00);
        expect_ev(7, K_ABORT, 16'd0);
        cmd(C_WR, 2'd2, 12'h000, 8'h00);
        chk(7, {15'd0, busy}, 16'd1);
        inhibit();
        chk(7, {15'd0, busy}, 16'd1);
        done_pulse();
        chk(7, {15'd0, busy}, 16'd0);
        expect_ev(9, K_READ, 16'h1000);             // R9 status idle
        cmd(C_RD, 2'd3, 12'h800, 8'h00);

        // R5: neutral commands inside the sequence
        cmd(C_LCR, 2'd0, 12'h040, 8'h00);
        cmd(C_BT, 2'd3, 12'h000, 8'h00);
        cmd(C_AT, 2'd2, 12'h000, 8'h00);
        inhibit();
        cmd(C_ACT, 2'd0, 12'h000, 8'h00);
        cmd(C_NOP, 2'd1, 12'h000, 8'h00);
        expect_ev(5, K_LAUNCH, {11'd0, 3'd2, 2'd0});
        cmd(C_WR, 2'd0, 12'h000, 8'h00);
        done_pulse();

        // R5: repeated LCR restarts with new code and bank; R12 block protect
        cmd(C_LCR, 2'd3, 12'h020, 8'h00);
        cmd(C_LCR, 2'd2, 12'h060, 8'h00);
        cmd(C_ACT, 2'd2, 12'h000, 8'h00);
        expect_ev(5, K_LAUNCH, {11'd0, 3'd3, 2'd2});
        cmd(C_WR, 2'd2, 12'h000, 8'h01);
        done_pulse();

        // R4: bank mismatch on activate, then on write
        cmd(C_LCR, 2'd0, 12'h020, 8'h00);
        expect_ev(4, K_ABORT, 16'd0);
        cmd(C_ACT, 2'd1, 12'h000, 8'h00);
        chk(4, {15'd0, busy}, 16'd0);
        cmd(C_LCR, 2'd0, 12'h040, 8'h00);
        cmd(C_ACT, 2'd0, 12'h000, 8'h00);
        expect_ev(4, K_ABORT, 16'd0);
        cmd(C_WR, 2'd3, 12'h000, 8'h00);

        // R4: device lock ignores bank; R12 device protect and unprotect
        cmd(C_LCR, 2'd0, 12'h06F, 8'h00);
        cmd(C_ACT, 2'd3, 12'h000, 8'h00);
        expect_ev(4, K_LAUNCH, {11'd0, 3'd4, 2'd0});
        cmd(C_WR, 2'd1, 12'h000, 8'hF1);
        done_pulse();
        cmd(C_LCR, 2'd1, 12'h060, 8'h00);
        cmd(C_ACT, 2'd1, 12'h000, 8'h00);
        expect_ev(12, K_LAUNCH, {11'd0, 3'd5, 2'd1});
        cmd(C_WR, 2'd1, 12'h000, 8'hD0);
        done_pulse();

        // R12: wrong lock data aborts
        cmd(C_LCR, 2'd1, 12'h060, 8'h00);
        cmd(C_ACT, 2'd1, 12'h000, 8'h00);
        expect_ev(12, K_ABORT, 16'd0);
        cmd(C_WR, 2'd1, 12'h000, 8'hF1);
        cmd(C_LCR, 2'd1, 12'h06F, 8'h00);
        cmd(C_ACT, 2'd1, 12'h000, 8'h00);
        expect_ev(12, K_ABORT, 16'd0);
        cmd(C_WR, 2'd1, 12'h000, 8'h55);

        // R6: out-of-order commands
        cmd(C_LCR, 2'd0, 12'h020, 8'h00);
        expect_ev(6, K_ABORT, 16'd0);
        cmd(C_WR, 2'd0, 12'h000, 8'h00);
        cmd(C_WR, 2'd0, 12'h000, 8'h00);            // R6 idle write: no event
        cmd(C_LCR, 2'd0, 12'h020, 8'h00);
        cmd(C_ACT, 2'd0, 12'h000, 8'h00);
        expect_ev(6, K_ABORT, 16'd0);
        expect_ev(6, K_READ, 16'h0000);
        cmd(C_RD, 2'd0, 12'h000, 8'h00);
        cmd(C_LCR, 2'd0, 12'h040, 8'h00);
        expect_ev(6, K_ABORT, 16'd0);               // R6 mode in sequence, no strobe
        cmd(C_MODE, 2'd0, 12'h040, 8'h00);
        cmd(C_LCR, 2'd0, 12'h055, 8'h00);           // R6 unknown code in idle
        cmd(C_ACT, 2'd0, 12'h0F0, 8'h00);
        expect_ev(6, K_READ, 16'h00F0);
        cmd(C_RD, 2'd0, 12'h000, 8'h00);

        // R10/R11: mode commands
        expect_ev(10, K_NVM, 16'h0123);
        cmd(C_MODE, 2'd0, 12'h123, 8'h00);
        chk(10, {15'd0, hw_cmd_en}, 16'd1);
        cmd(C_MODE, 2'd2, 12'h000, 8'h00);
        chk(11, {15'd0, hw_cmd_en}, 16'd0);
        cmd(C_MODE, 2'd3, 12'h000, 8'h00);
        expect_ev(11, K_NVM, 16'h0456);
        cmd(C_MODE, 2'd1, 12'h456, 8'h00);
        chk(11, {15'd0, hw_cmd_en}, 16'd0);

        repeat (4) inhibit();
        chk(2, 16'(sbq.size()), 16'd0);             // R2 no expected event left
        finish_run();
    end

endmodule